// File: doc/BRIEF.md
# Parallel Flash Query Probe Engine

This block finds out, after reset and on request, how a parallel NOR flash that answers the common flash query convention is organised. When `start` is pulsed it takes over a simple flash bus: a byte address, write data, a write strobe, a read strobe and read data that arrives one cycle after the read strobe. It tries data-bus widths of one, two and four bytes in that order. At each width it enters query mode and looks for the three-letter identification string.

Once the string is found, the engine reads a fixed set of query bytes. From these it builds the 16-bit command-set identifier, the device size, the interface capability code and up to four erase-region descriptors. Every query byte is fetched with its own enter, read and leave sequence, so the flash is back in read-array mode whenever the engine is between reads and after it finishes. The results are held on registered outputs. A one-cycle `done` pulse marks the end of the probe, and `error` and `err_code` give its outcome.

Top module: `flash_probe`

## Requirements
- R1: The probe tries widths 1, 2 and 4 bytes in turn. It stops at the first width whose byte at query offset 0x10 equals 0x51 ('Q') and reports that width on `width` as 1, 2 or 4.
- R2: Each query read has three bus operations. First, a write of 0x98 at address 0x55 times the width. Next, a read at the query offset times the width, aligned down to the width, whose low byte is used. Last, a write of 0xFF at address 0. The number of reads equals the number of query bytes the probe needs, and the flash ends in read-array mode.
- R3: If no width gives 'Q', `done` pulses with `error` high and `err_code` = 1.
- R4: If offset 0x11 is not 0x52 ('R') or offset 0x12 is not 0x59 ('Y'), the probe ends with `error` high and `err_code` = 2.
- R5: `cmd_set` is the byte at offset 0x14 above the byte at offset 0x13.
- R6: `dev_size` equals 1 shifted left by the byte at offset 0x27. The result is zero when that byte is 32 or more.
- R7: The interface code is the byte at 0x29 above the byte at 0x28. One is added to it. If the result has no bit in common with the detected width, the probe ends with `error` high and `err_code` = 3.
- R8: The region count is read at offset 0x2C. Region r takes four bytes starting at 0x2D + 4r: a little-endian block-count field, then a little-endian size field. The block count is reported as the block-count field plus one, 17 bits per region in `region_blocks`.
- R9: A region's block size in bytes is 128 when its size field is zero, and the field times 256 otherwise. It is reported as 24 bits per region in `region_bsize`.
- R10: When the region count is above 4, only the first four regions are read. `region_cnt` is 4 and `region_ovf` is set. A count of zero finishes the probe successfully with no regions read.
- R11: After reset and at each `start`, all result outputs are zero. `done` is high for exactly one cycle, with `error` = 0 and `err_code` = 0 on success. All results hold their values until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a probe when the engine is idle |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | DATA_W | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe; data is expected on the next cycle |
| fl_rdata | input | DATA_W | Flash read data, little-endian |
| done | output | 1 | One-cycle end-of-probe pulse |
| error | output | 1 | Probe failed |
| err_code | output | 2 | 0 none, 1 no signature, 2 bad signature, 3 bad interface |
| width | output | 3 | Detected width in bytes |
| cmd_set | output | 16 | Command-set identifier |
| dev_size | output | SIZE_W | Device size in bytes |
| region_cnt | output | CNT_W | Number of erase regions stored |
| region_ovf | output | 1 | The flash reported more regions than are stored |
| region_blocks | output | MAX_REG*17 | Block count per region, region 0 in the low bits |
| region_bsize | output | MAX_REG*24 | Block size in bytes per region, region 0 in the low bits |

## Verification
A wrong read-phase state shows up at the bus within a few cycles. It appears as a write that is neither the query command nor the read-array command, or as a read count that differs from the number of bytes the flash's table calls for. A wrong item or width register shows up at the single `done` pulse, as a width, error code or captured field that disagrees with the modelled table. A region index off by one moves descriptors into the wrong output slot. The flash is modelled at every width, absent, with a broken signature, with a bad interface code, with zero regions and with too many regions.

// File: rtl/fqp_pkg.sv
package fqp_pkg;
  localparam logic [7:0] QRY_ADDR   = 8'h55;
  localparam logic [7:0] QRY_CMD    = 8'h98;
  localparam logic [7:0] ARRAY_CMD  = 8'hFF;
  localparam logic [7:0] OFS_SIG    = 8'h10;
  localparam logic [7:0] OFS_CSET   = 8'h13;
  localparam logic [7:0] OFS_SIZE   = 8'h27;
  localparam logic [7:0] OFS_IFC    = 8'h28;
  localparam logic [7:0] OFS_NREG   = 8'h2C;
  localparam logic [7:0] OFS_REGT   = 8'h2D;

  typedef enum logic [1:0] {ERR_NONE, ERR_NOSIG, ERR_BADSIG, ERR_IFACE} err_e;
  typedef enum logic [2:0] {PH_IDLE, PH_CMD, PH_RD, PH_CAP, PH_EXIT} phase_e;
  typedef enum logic [3:0] {IT_Q, IT_R, IT_Y, IT_CS0, IT_CS1, IT_SZ,
                            IT_IF0, IT_IF1, IT_NREG, IT_REG} item_e;
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} ctl_e;
endpackage

// File: rtl/qry_bus_seq.sv
module qry_bus_seq import fqp_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [2:0]        width_b,
  input  logic [7:0]        ofs,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  output logic              fl_we,
  output logic              fl_re,
  input  logic [DATA_W-1:0] fl_rdata,
  output logic [7:0]        byte_o,
  output logic              rd_done
);
  phase_e ph;
  logic [7:0] byte_q;
  logic [ADDR_W-1:0] wmask, cmd_a, rd_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      byte_q <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: if (go) ph <= PH_CMD;
        PH_CMD:  ph <= PH_RD;
        PH_RD:   ph <= PH_CAP;
        PH_CAP: begin
          byte_q <= fl_rdata[7:0];
          ph     <= PH_EXIT;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    wmask = ~(ADDR_W'(width_b) - ADDR_W'(1));
    cmd_a = (ADDR_W'(QRY_ADDR) * ADDR_W'(width_b)) & wmask;
    rd_a  = (ADDR_W'(ofs) * ADDR_W'(width_b)) & wmask;
    fl_we    = (ph == PH_CMD) || (ph == PH_EXIT);
    fl_re    = (ph == PH_RD);
    fl_addr  = '0;
    fl_wdata = '0;
    if (ph == PH_CMD) begin
      fl_addr  = cmd_a;
      fl_wdata = DATA_W'(QRY_CMD);
    end else if (ph == PH_RD) begin
      fl_addr  = rd_a;
    end else if (ph == PH_EXIT) begin
      fl_wdata = DATA_W'(ARRAY_CMD);
    end
  end

  assign byte_o  = byte_q;
  assign rd_done = (ph == PH_EXIT);
endmodule

// File: rtl/region_tbl.sv
module region_tbl #(
  parameter int MAX_REG = 4,
  parameter int BLK_W   = 17,
  parameter int SZ_W    = 24,
  localparam int IDX_W  = (MAX_REG > 1) ? $clog2(MAX_REG) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     we,
  input  logic [IDX_W-1:0]         idx,
  input  logic [15:0]              blk_field,
  input  logic [15:0]              sz_field,
  output logic [MAX_REG*BLK_W-1:0] blocks_o,
  output logic [MAX_REG*SZ_W-1:0]  bsize_o
);
  logic [BLK_W-1:0] blk_v;
  logic [SZ_W-1:0]  sz_v;

  always_comb begin
    blk_v = BLK_W'(blk_field) + BLK_W'(1);
    sz_v  = (sz_field == 16'd0) ? SZ_W'(128) : SZ_W'({sz_field, 8'd0});
  end

  for (genvar g = 0; g < MAX_REG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        blocks_o[g*BLK_W +: BLK_W] <= '0;
        bsize_o[g*SZ_W +: SZ_W]    <= '0;
      end else if (we && (idx == IDX_W'(g))) begin
        blocks_o[g*BLK_W +: BLK_W] <= blk_v;
        bsize_o[g*SZ_W +: SZ_W]    <= sz_v;
      end
    end
  end
endmodule

// File: rtl/flash_probe.sv
module flash_probe import fqp_pkg::*; #(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  parameter int MAX_REG = 4,
  parameter int SIZE_W  = 32,
  localparam int CNT_W  = $clog2(MAX_REG + 1),
  localparam int IDX_W  = (MAX_REG > 1) ? $clog2(MAX_REG) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  output logic [ADDR_W-1:0]     fl_addr,
  output logic [DATA_W-1:0]     fl_wdata,
  output logic                  fl_we,
  output logic                  fl_re,
  input  logic [DATA_W-1:0]     fl_rdata,
  output logic                  done,
  output logic                  error,
  output logic [1:0]            err_code,
  output logic [2:0]            width,
  output logic [15:0]           cmd_set,
  output logic [SIZE_W-1:0]     dev_size,
  output logic [CNT_W-1:0]      region_cnt,
  output logic                  region_ovf,
  output logic [MAX_REG*17-1:0] region_blocks,
  output logic [MAX_REG*24-1:0] region_bsize
);
  ctl_e  st;
  item_e item, nitem;
  err_e  fcode;
  logic  fin, idle_w, rd_done, tbl_we, go_w;
  logic [7:0]  b, ofs;
  logic [7:0]  ifc_lo;
  logic [15:0] ifc_p1;
  logic [23:0] acc;
  logic [1:0]  k;
  logic [IDX_W-1:0] r_idx;
  logic [CNT_W-1:0] cnt_in;

  assign idle_w = (st == S_IDLE);
  assign go_w   = (st == S_ISSUE);

  qry_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst(rst), .go(go_w), .width_b(width), .ofs(ofs),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(fl_rdata), .byte_o(b), .rd_done(rd_done)
  );

  // query offset of the current item
  always_comb begin
    unique case (item)
      IT_Q:    ofs = OFS_SIG;
      IT_R:    ofs = OFS_SIG + 8'd1;
      IT_Y:    ofs = OFS_SIG + 8'd2;
      IT_CS0:  ofs = OFS_CSET;
      IT_CS1:  ofs = OFS_CSET + 8'd1;
      IT_SZ:   ofs = OFS_SIZE;
      IT_IF0:  ofs = OFS_IFC;
      IT_IF1:  ofs = OFS_IFC + 8'd1;
      IT_NREG: ofs = OFS_NREG;
      default: ofs = OFS_REGT + 8'({r_idx, k});
    endcase
  end

  // decision taken on each returned byte
  always_comb begin
    fin    = 1'b0;
    fcode  = ERR_NONE;
    nitem  = item;
    ifc_p1 = {b, ifc_lo} + 16'd1;
    cnt_in = (b > 8'(MAX_REG)) ? CNT_W'(MAX_REG) : CNT_W'(b);
    unique case (item)
      IT_Q:   if (b == 8'h51) nitem = IT_R;
              else if (width == 3'd4) begin fin = 1'b1; fcode = ERR_NOSIG; end
      IT_R:   if (b == 8'h52) nitem = IT_Y;
              else begin fin = 1'b1; fcode = ERR_BADSIG; end
      IT_Y:   if (b == 8'h59) nitem = IT_CS0;
              else begin fin = 1'b1; fcode = ERR_BADSIG; end
      IT_CS0: nitem = IT_CS1;
      IT_CS1: nitem = IT_SZ;
      IT_SZ:  nitem = IT_IF0;
      IT_IF0: nitem = IT_IF1;
      IT_IF1: if ((ifc_p1 & {13'd0, width}) != 16'd0) nitem = IT_NREG;
              else begin fin = 1'b1; fcode = ERR_IFACE; end
      IT_NREG: if (b == 8'd0) fin = 1'b1;
               else nitem = IT_REG;
      default: if (k == 2'd3 && (CNT_W'(r_idx) + CNT_W'(1)) == region_cnt) fin = 1'b1;
    endcase
  end

  assign tbl_we = (st == S_WAIT) && rd_done && (item == IT_REG) && (k == 2'd3);

  region_tbl #(.MAX_REG(MAX_REG), .BLK_W(17), .SZ_W(24)) tbl_i (
    .clk(clk), .rst(rst), .clr(idle_w && start), .we(tbl_we), .idx(r_idx),
    .blk_field(acc[15:0]), .sz_field({b, acc[23:16]}),
    .blocks_o(region_blocks), .bsize_o(region_bsize)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; item <= IT_Q; done <= 1'b0; error <= 1'b0;
      err_code <= '0; width <= '0; cmd_set <= '0; dev_size <= '0;
      region_cnt <= '0; region_ovf <= 1'b0; ifc_lo <= '0; acc <= '0;
      k <= '0; r_idx <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (start) begin
          st <= S_ISSUE; item <= IT_Q; width <= 3'd1; error <= 1'b0;
          err_code <= '0; cmd_set <= '0; dev_size <= '0; region_cnt <= '0;
          region_ovf <= 1'b0; ifc_lo <= '0; acc <= '0; k <= '0; r_idx <= '0;
        end
        S_ISSUE: st <= S_WAIT;
        default: if (rd_done) begin
          unique case (item)
            IT_Q:    if (b != 8'h51 && width != 3'd4) width <= width << 1;
            IT_CS0:  cmd_set[7:0]  <= b;
            IT_CS1:  cmd_set[15:8] <= b;
            IT_SZ:   dev_size <= SIZE_W'(1) << b;
            IT_IF0:  ifc_lo <= b;
            IT_NREG: begin
              region_cnt <= cnt_in;
              region_ovf <= (b > 8'(MAX_REG));
            end
            IT_REG: begin
              acc[k*8 +: 8] <= b;
              k <= k + 2'd1;
              if (k == 2'd3) r_idx <= r_idx + IDX_W'(1);
            end
            default: ;
          endcase
          item <= nitem;
          if (fin) begin
            st <= S_IDLE; done <= 1'b1;
            error <= (fcode != ERR_NONE); err_code <= fcode;
          end else begin
            st <= S_ISSUE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/flash_probe_chk.sv
module flash_probe_chk #(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  parameter int MAX_REG = 4,
  parameter int CNT_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              idle,
  input logic              done,
  input logic              error,
  input logic [1:0]        err_code,
  input logic [2:0]        width,
  input logic [15:0]       cmd_set,
  input logic              fl_we,
  input logic              fl_re,
  input logic [ADDR_W-1:0] fl_addr,
  input logic [DATA_W-1:0] fl_wdata,
  input logic [CNT_W-1:0]  region_cnt,
  input logic              region_ovf
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R2
  bus_excl_chk: assert property (@(posedge clk) disable iff (rst) !(fl_we && fl_re));
  // R2
  wr_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    fl_we |-> (fl_wdata == DATA_W'(8'h98)) || (fl_wdata == DATA_W'(8'hFF) && fl_addr == '0));
  // R3
  err_flag_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (error == (err_code != 2'd0)));
  // R1
  width_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !error) |-> ($countones(width) == 1 && width != 3'd0));
  // R10
  cnt_chk: assert property (@(posedge clk) disable iff (rst)
    region_ovf |-> (region_cnt == CNT_W'(MAX_REG)));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (idle && !start) |=> ($stable(cmd_set) && $stable(error) && $stable(width)));
endmodule

bind flash_probe flash_probe_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_REG(MAX_REG),
  .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .idle(idle_w), .done(done), .error(error),
  .err_code(err_code), .width(width), .cmd_set(cmd_set), .fl_we(fl_we), .fl_re(fl_re),
  .fl_addr(fl_addr), .fl_wdata(fl_wdata), .region_cnt(region_cnt), .region_ovf(region_ovf)
);

// File: tb/flash_probe_tb_top.sv
module flash_probe_tb_top;
  localparam int MAXR = 4;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [23:0] fl_addr;
  logic [31:0] fl_wdata, fl_rdata;
  logic fl_we, fl_re, done, error, region_ovf;
  logic [1:0] err_code;
  logic [2:0] width;
  logic [15:0] cmd_set;
  logic [31:0] dev_size;
  logic [2:0] region_cnt;
  logic [MAXR*17-1:0] region_blocks;
  logic [MAXR*24-1:0] region_bsize;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  flash_probe dut_i (
    .clk(clk), .rst(rst), .start(start), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata), .done(done), .error(error),
    .err_code(err_code), .width(width), .cmd_set(cmd_set), .dev_size(dev_size),
    .region_cnt(region_cnt), .region_ovf(region_ovf), .region_blocks(region_blocks),
    .region_bsize(region_bsize)
  );

  // flash model
  logic [2:0] m_w = 3'd0;
  logic m_q;
  logic [7:0] qmem [128];
  int rd_cnt;
  logic cnt_clr = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_q <= 1'b0; fl_rdata <= '0;
    end else begin
      if (fl_we) begin
        if (m_w != 0 && fl_addr == 24'(8'h55) * 24'(m_w) && fl_wdata[7:0] == 8'h98) m_q <= 1'b1;
        else if (fl_wdata[7:0] == 8'hFF) m_q <= 1'b0;
      end
      if (fl_re) begin
        if (m_q && m_w != 0 && (fl_addr % 24'(m_w)) == 0 && (fl_addr / 24'(m_w)) < 128)
          fl_rdata <= {24'd0, qmem[fl_addr / 24'(m_w)]};
        else
          fl_rdata <= 32'hFFFF_FFFF;
      end
    end
  end

  always @(posedge clk) begin
    if (cnt_clr) rd_cnt <= 0;
    else if (fl_re) rd_cnt <= rd_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] blkf(int r);
    return 16'h0007 + 16'(r) * 16'h0100;
  endfunction
  function automatic logic [15:0] szf(int r);
    return (r == 1) ? 16'h0000 : 16'h0020 + 16'(r);
  endfunction

  // {width[3], badsig[1], cmdset[16], size[8], iface[16], nreg[8]}
  localparam logic [51:0] VEC [8] = '{
    {3'd1, 1'b0, 16'h0002, 8'h16, 16'h0000, 8'd1},
    {3'd2, 1'b0, 16'h0001, 8'h17, 16'h0001, 8'd2},
    {3'd4, 1'b0, 16'h0003, 8'h18, 16'h0003, 8'd4},
    {3'd2, 1'b0, 16'h0002, 8'h15, 16'h0000, 8'd1},
    {3'd0, 1'b0, 16'h0000, 8'h00, 16'h0000, 8'd0},
    {3'd1, 1'b1, 16'h0002, 8'h16, 16'h0000, 8'd1},
    {3'd4, 1'b0, 16'h0102, 8'h19, 16'h0005, 8'd6},
    {3'd2, 1'b0, 16'h0003, 8'h14, 16'h0002, 8'd0}
  };

  task automatic load(input logic [51:0] v);
    logic [15:0] cs, ifc;
    int nr;
    m_w = v[51:49];
    cs  = v[47:32];
    ifc = v[23:8];
    nr  = int'(v[7:0]);
    for (int i = 0; i < 128; i++) qmem[i] = 8'h00;
    qmem[8'h10] = 8'h51; qmem[8'h11] = 8'h52; qmem[8'h12] = v[48] ? 8'h5A : 8'h59;
    qmem[8'h13] = cs[7:0]; qmem[8'h14] = cs[15:8];
    qmem[8'h27] = v[31:24];
    qmem[8'h28] = ifc[7:0]; qmem[8'h29] = ifc[15:8];
    qmem[8'h2C] = v[7:0];
    for (int r = 0; r < nr; r++) begin
      if (8'h2D + 4*r + 3 < 128) begin
        qmem[8'h2D + 4*r]     = blkf(r) & 16'hFF;
        qmem[8'h2D + 4*r + 1] = blkf(r) >> 8;
        qmem[8'h2D + 4*r + 2] = szf(r) & 16'hFF;
        qmem[8'h2D + 4*r + 3] = szf(r) >> 8;
      end
    end
  endtask

  task automatic run_probe(output bit got);
    got = 1'b0;
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int t = 0; t < 3000 && !got; t++) begin
      if (done) got = 1'b1;
      else @(negedge clk);
    end
    chk(got, "R11 done timeout", 0, 1);
  endtask

  initial begin
    bit got;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!done && !error && err_code == 0 && width == 0 && cmd_set == 0 && dev_size == 0
        && region_cnt == 0 && !region_ovf && region_blocks == 0 && region_bsize == 0,
        "R11 reset", {err_code, width}, 0);
    chk(!fl_we && !fl_re, "R2 idle bus", {fl_we, fl_re}, 0);

    foreach (VEC[i]) begin
      logic [51:0] v;
      logic [2:0] mw;
      logic [16:0] ip;
      int exp_code, nr, cnt, q_tries, exp_reads;
      v  = VEC[i];
      mw = v[51:49];
      nr = int'(v[7:0]);
      cnt = (nr > MAXR) ? MAXR : nr;
      ip = 17'(v[23:8]) + 17'd1;
      if (mw == 0) exp_code = 1;
      else if (v[48]) exp_code = 2;
      else if ((ip & 17'(mw)) == 0) exp_code = 3;
      else exp_code = 0;
      q_tries = (mw == 1) ? 1 : (mw == 2) ? 2 : 3;
      load(v);
      run_probe(got);
      if (!got) continue;
      // R3 R4 R7 error reporting
      chk(err_code == 2'(exp_code) && error == (exp_code != 0),
          "R3/R4/R7 err_code", err_code, exp_code);
      if (exp_code == 1) begin
        chk(region_cnt == 0 && cmd_set == 0, "R3 nothing captured", cmd_set, 0);
        chk(rd_cnt == 3, "R1 three widths tried", rd_cnt, 3);
      end
      if (exp_code == 2) chk(rd_cnt == q_tries + 2, "R4 stops at Y", rd_cnt, q_tries + 2);
      if (exp_code != 1) chk(width == mw, "R1 width", width, mw);
      if (exp_code == 0 || exp_code == 3) begin
        chk(cmd_set == v[47:32], "R5 cmd_set", cmd_set, v[47:32]);
        chk(dev_size == (32'd1 << v[31:24]), "R6 dev_size", dev_size, 32'd1 << v[31:24]);
      end
      if (exp_code == 0) begin
        exp_reads = q_tries + 2 + 6 + 4 * cnt;
        chk(rd_cnt == exp_reads, "R2 read count", rd_cnt, exp_reads);
        chk(region_cnt == 3'(cnt), "R10 region_cnt", region_cnt, cnt);
        chk(region_ovf == (nr > MAXR), "R10 region_ovf", region_ovf, nr > MAXR);
        for (int r = 0; r < MAXR; r++) begin
          logic [16:0] eb;
          logic [23:0] es;
          eb = (r < cnt) ? 17'(blkf(r)) + 17'd1 : 17'd0;
          es = (r < cnt) ? ((szf(r) == 0) ? 24'd128 : {szf(r), 8'd0}) : 24'd0;
          chk(region_blocks[r*17 +: 17] == eb, "R8 blocks", region_blocks[r*17 +: 17], eb);
          chk(region_bsize[r*24 +: 24] == es, "R9 bsize", region_bsize[r*24 +: 24], es);
        end
      end
      if (exp_code == 3) chk(rd_cnt == q_tries + 2 + 5, "R7 stops at iface", rd_cnt, q_tries + 7);
      // R11 single-cycle done, then hold
      @(negedge clk);
      chk(!done, "R11 done pulse", done, 0);
      // R2 flash left in read-array mode
      chk(!m_q, "R2 read-array exit", m_q, 0);
      begin
        logic [15:0] cs0;
        logic [2:0] w0;
        logic e0;
        cs0 = cmd_set; w0 = width; e0 = error;
        repeat (10) @(negedge clk);
        chk(cmd_set == cs0 && width == w0 && error == e0 && !done, "R11 hold", cmd_set, cs0);
      end
    end

    // R11 results cleared at the next start
    load(VEC[2]);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(cmd_set == 0 && region_cnt == 0 && !error, "R11 clear on start", cmd_set, 0);
    for (int t = 0; t < 3000 && !done; t++) @(negedge clk);
    chk(done && cmd_set == 16'h0003, "R11 rerun", cmd_set, 16'h0003);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R11 watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule